// File: doc/BRIEF.md
# 64-bit Programmable Interval Timer

This block is one timer channel with a 64-bit counter, set up and observed through a 32-bit register port. Software writes a 64-bit start value and a 64-bit terminal value, each split into a low and a high word. It then sets the enable bit. On that enable the counter takes the start value and then advances by one on every clock. When it reaches the terminal value it raises a sticky status bit, which drives the interrupt line.

Two behaviours follow a hit, and a control bit picks between them. In periodic mode the counter goes back to the start value and runs again, so the interrupt recurs every (terminal − start + 1) cycles. In one-shot mode the counter parks on the terminal value until software turns the enable off and on again. The live count can be read at any time. Reading its low word captures the high word, so a following high-word read gives a consistent 64-bit value even when a carry crosses the word boundary between the two reads.

Top module: `sec_timer64`

## Requirements
- R1: Byte offsets: terminal value low 0x00, high 0x04; live count low 0x08, high 0x0C; start value low 0x10, high 0x14; status 0x18 (bit 0); control 0x1C (bit 0 enable, bit 1 mode, 0 = periodic, 1 = one-shot). Terminal, start and control read back what was written. Any other offset reads zero.
- R2: After a synchronous active-low reset, every register and the count read zero and `irq` is low.
- R3: A write to control with bit 0 set, while the enable is clear, loads the count with the start value at that clock edge.
- R4: While enabled and not parked, the count rises by exactly one per clock as long as it differs from the terminal value.
- R5: On a clock edge where a running count equals the terminal value, the status bit is set. `irq` always equals the status bit. Writing 1 to status bit 0 clears it, and a new hit in the same cycle wins over the clear.
- R6: In periodic mode the count returns to the start value on the edge that sets status, giving a period of terminal − start + 1 clocks.
- R7: In one-shot mode the count stays at the terminal value after the hit. Status is not set again until the timer is re-enabled.
- R8: Clearing the enable freezes the count. Setting it again restarts from the start value.
- R9: A read strobe at offset 0x08 captures the high word of the live count. Offset 0x0C returns that captured word and not the live one.
- R10: Writes to 0x08 and 0x0C have no effect, and writing 0 to status bit 0 leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rd | input | 1 | Read strobe (drives the high-word capture) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt, equal to the status bit |

## Verification
The embedded properties check on every cycle that the count loads on the enable edge, steps by one, reloads or parks at the terminal value, and freezes while disabled. They also check that a status rise always follows a terminal match and that the captured high word matches the count at the low-word read. Only the bench scenarios can show the results that depend on register contents and sequencing. These are the read-back of every offset, the carry across the 32-bit boundary, the coherent read pair across that carry, ignored writes, and the full periodic and one-shot sequences, all compared against a behavioural model clock by clock.

// File: rtl/tmr_pkg.sv
// Shared constants for the 64-bit timer: register byte offsets and the
// counting phase. Assumes byte addressing with 32-bit aligned registers.
package tmr_pkg;
    localparam int unsigned OFF_END_LO  = 32'h00;
    localparam int unsigned OFF_END_HI  = 32'h04;
    localparam int unsigned OFF_CUR_LO  = 32'h08;
    localparam int unsigned OFF_CUR_HI  = 32'h0C;
    localparam int unsigned OFF_INIT_LO = 32'h10;
    localparam int unsigned OFF_INIT_HI = 32'h14;
    localparam int unsigned OFF_STAT    = 32'h18;
    localparam int unsigned OFF_CTRL    = 32'h1C;

    // Control bit positions
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;

    // Counting phase: counting, or parked at terminal value (one-shot)
    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_HELD  = 1'b1
    } phase_t;
endpackage

// File: rtl/tmr_cfg_regs.sv
// Configuration registers: terminal value, start value and control.
// Decodes writes and produces the enable-edge and status-clear pulses.
// Assumes one-clock write strobes and a synchronous active-low reset.
module tmr_cfg_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  end_cnt,
    output logic [CNT_W-1:0]  init_cnt,
    output logic              tmr_en,
    output logic              tmr_mode,
    output logic              en_rise,
    output logic              stat_clr
);
    logic hit_ctrl;
    logic hit_stat;

    // Address match for the control and status offsets
    assign hit_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign hit_stat = wr_en && (addr == ADDR_W'(OFF_STAT));

    // Enable edge: enable bit written as 1 while currently clear
    assign en_rise  = hit_ctrl && wdata[CTRL_EN_BIT] && !tmr_en;
    // Write-one-to-clear request for the status bit
    assign stat_clr = hit_stat && wdata[0];

    // Register file update from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_cnt  <= '0;
            init_cnt <= '0;
            tmr_en   <= 1'b0;
            tmr_mode <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFF_END_LO))  end_cnt[DATA_W-1:0]      <= wdata;
            if (addr == ADDR_W'(OFF_END_HI))  end_cnt[CNT_W-1:DATA_W]  <= wdata;
            if (addr == ADDR_W'(OFF_INIT_LO)) init_cnt[DATA_W-1:0]     <= wdata;
            if (addr == ADDR_W'(OFF_INIT_HI)) init_cnt[CNT_W-1:DATA_W] <= wdata;
            if (hit_ctrl) begin
                tmr_en   <= wdata[CTRL_EN_BIT];
                tmr_mode <= wdata[CTRL_MODE_BIT];
            end
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
// Counting core: 64-bit up-counter with terminal compare, periodic reload
// or one-shot park, and the sticky status bit. Assumes en_rise occurs only
// while tmr_en is clear.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             tmr_mode,
    input  logic             en_rise,
    input  logic             stat_clr,
    input  logic [CNT_W-1:0] end_cnt,
    input  logic [CNT_W-1:0] init_cnt,
    output logic [CNT_W-1:0] count,
    output logic             status
);
    phase_t phase;
    logic   running;
    logic   hit;

    // Counting qualifies on enable and not parked; hit is the terminal match
    assign running = tmr_en && (phase == PH_COUNT);
    assign hit     = running && (count == end_cnt);

    // Count and phase: load on enable edge, reload or park on hit, else step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            phase <= PH_COUNT;
        end else if (en_rise) begin
            count <= init_cnt;
            phase <= PH_COUNT;
        end else if (hit) begin
            if (!tmr_mode) count <= init_cnt;
            else           phase <= PH_HELD;
        end else if (running) begin
            count <= count + 1'b1;
        end
    end

    // Sticky status: set on hit, cleared by write-one, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (hit)      status <= 1'b1;
        else if (stat_clr) status <= 1'b0;
    end

    p_load_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> count == $past(init_cnt));

    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count != end_cnt && !en_rise) |=> count == $past(count) + 1'b1);

    p_status_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(running && count == end_cnt));

    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == end_cnt && !tmr_mode) |=> (count == $past(init_cnt)) && status);

    p_oneshot_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HELD && !en_rise) |=> $stable(count) && !$rose(status));

    p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !en_rise) |=> $stable(count));
endmodule

// File: rtl/tmr_read_mux.sv
// Read path: selects register data by offset and captures the live high
// word on a low-word read strobe so a two-word read is coherent.
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  end_cnt,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic              status,
    input  logic              tmr_en,
    input  logic              tmr_mode,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] hi_snap;
    logic              lo_read;

    assign lo_read = rd_en && (addr == ADDR_W'(OFF_CUR_LO));

    // Capture the live high word when the low word is read
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_snap <= '0;
        else if (lo_read) hi_snap <= count[CNT_W-1:DATA_W];
    end

    // Offset-to-data selection; unmapped offsets read zero
    always_comb begin
        rdata = '0;
        case (32'(addr))
            OFF_END_LO:  rdata = end_cnt[DATA_W-1:0];
            OFF_END_HI:  rdata = end_cnt[CNT_W-1:DATA_W];
            OFF_CUR_LO:  rdata = count[DATA_W-1:0];
            OFF_CUR_HI:  rdata = hi_snap;
            OFF_INIT_LO: rdata = init_cnt[DATA_W-1:0];
            OFF_INIT_HI: rdata = init_cnt[CNT_W-1:DATA_W];
            OFF_STAT:    rdata = DATA_W'(status);
            OFF_CTRL:    rdata = DATA_W'({tmr_mode, tmr_en});
            default:     rdata = '0;
        endcase
    end

    p_snapshot_coherent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_read |=> hi_snap == $past(count[CNT_W-1:DATA_W]));
endmodule

// File: rtl/sec_timer64.sv
// Top of the 64-bit programmable interval timer: register port, counting
// core and read path. Assumes a single clock and synchronous reset.
module sec_timer64 #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] end_cnt;
    logic [CNT_W-1:0] init_cnt;
    logic [CNT_W-1:0] count;
    logic             tmr_en;
    logic             tmr_mode;
    logic             en_rise;
    logic             stat_clr;
    logic             status;

    tmr_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .end_cnt  (end_cnt),
        .init_cnt (init_cnt),
        .tmr_en   (tmr_en),
        .tmr_mode (tmr_mode),
        .en_rise  (en_rise),
        .stat_clr (stat_clr)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_en   (tmr_en),
        .tmr_mode (tmr_mode),
        .en_rise  (en_rise),
        .stat_clr (stat_clr),
        .end_cnt  (end_cnt),
        .init_cnt (init_cnt),
        .count    (count),
        .status   (status)
    );

    tmr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .count    (count),
        .end_cnt  (end_cnt),
        .init_cnt (init_cnt),
        .status   (status),
        .tmr_en   (tmr_en),
        .tmr_mode (tmr_mode),
        .rdata    (reg_rdata)
    );

    // Interrupt line mirrors the sticky status bit
    assign irq = status;
endmodule

// File: tb/sec_timer64_bench.sv
module sec_timer64_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sec_timer64 u_sec_timer64 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // Behavioural reference model, updated on each rising edge
    logic [63:0] m_end, m_init, m_cnt;
    logic [31:0] m_snap;
    logic        m_en, m_mode, m_stat, m_done;

    always @(posedge clk) begin
        logic        hit;
        logic        run;
        logic [63:0] nc;
        if (!rst_n) begin
            m_end <= '0; m_init <= '0; m_cnt <= '0; m_snap <= '0;
            m_en <= 0; m_mode <= 0; m_stat <= 0; m_done <= 0;
        end else begin
            run = m_en && !m_done;
            hit = run && (m_cnt == m_end);
            nc  = m_cnt;
            if (reg_wr && reg_addr == 5'h1C && reg_wdata[0] && !m_en) begin
                nc = m_init;
                m_done <= 0;
            end else if (hit) begin
                if (m_mode) m_done <= 1;
                else        nc = m_init;
            end else if (run) begin
                nc = m_cnt + 64'd1;
            end
            m_cnt <= nc;
            if (hit) m_stat <= 1;
            else if (reg_wr && reg_addr == 5'h18 && reg_wdata[0]) m_stat <= 0;
            if (reg_rd && reg_addr == 5'h08) m_snap <= m_cnt[63:32];
            if (reg_wr) begin
                case (reg_addr)
                    5'h00: m_end[31:0]   <= reg_wdata;
                    5'h04: m_end[63:32]  <= reg_wdata;
                    5'h10: m_init[31:0]  <= reg_wdata;
                    5'h14: m_init[63:32] <= reg_wdata;
                    5'h1C: begin m_en <= reg_wdata[0]; m_mode <= reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00: return m_end[31:0];
            5'h04: return m_end[63:32];
            5'h08: return m_cnt[31:0];
            5'h0C: return m_snap;
            5'h10: return m_init[31:0];
            5'h14: return m_init[63:32];
            5'h18: return {31'b0, m_stat};
            5'h1C: return {30'b0, m_mode, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Interrupt compared with the model on every clock (R5)
    always @(negedge clk) begin
        if (rst_n && !finished) chk("R5 irq equals status", {63'b0, irq}, {63'b0, m_stat});
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1;
        chk(tag, {32'b0, reg_rdata}, {32'b0, mread(a)});
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        #1;
        chk("R2 irq low in reset", {63'b0, irq}, 64'd0);
        @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 32; a += 4) rd(5'(a), "R2 reset value");
        rd(5'h02, "R1 unmapped offset reads zero");

        // Start value just below a 32-bit carry; period 7
        wr(5'h00, 32'h0000_0002);
        wr(5'h04, 32'h0000_0001);
        wr(5'h10, 32'hFFFF_FFFC);
        wr(5'h14, 32'h0000_0000);
        rd(5'h00, "R1 terminal low readback");
        rd(5'h04, "R1 terminal high readback");
        rd(5'h10, "R1 start low readback");
        rd(5'h14, "R1 start high readback");

        wr(5'h1C, 32'h1);
        rd(5'h1C, "R1 control readback");
        rd(5'h08, "R3 count after enable");
        rd(5'h0C, "R4 high word across carry");
        rd(5'h08, "R4 count step");
        rd(5'h0C, "R9 captured high word");
        idle(9);
        rd(5'h08, "R6 periodic reload count");
        rd(5'h18, "R5 status set after hit");
        wr(5'h18, 32'h0);
        rd(5'h18, "R10 zero write keeps status");
        wr(5'h18, 32'h1);
        rd(5'h18, "R5 write one clears status");
        wr(5'h08, 32'h1234_5678);
        wr(5'h0C, 32'h1234_5678);
        rd(5'h08, "R10 count write ignored");
        rd(5'h0C, "R10 high write ignored");

        // Coherent pair: low read, delay, high read
        for (int k = 0; k < 7; k++) begin
            rd(5'h08, "R9 low word read");
            idle(k);
            rd(5'h0C, "R9 coherent high word");
        end

        // Disable freezes count
        wr(5'h1C, 32'h0);
        rd(5'h08, "R8 frozen count");
        idle(6);
        rd(5'h08, "R8 still frozen");

        // One-shot mode
        wr(5'h1C, 32'h3);
        rd(5'h08, "R3 reload on re-enable");
        idle(12);
        rd(5'h08, "R7 parked at terminal");
        wr(5'h18, 32'h1);
        idle(10);
        rd(5'h18, "R7 no second status set");
        rd(5'h08, "R7 still parked");

        // Disable then enable restarts
        wr(5'h1C, 32'h2);
        wr(5'h1C, 32'h3);
        rd(5'h08, "R8 restart from start value");
        idle(10);
        rd(5'h18, "R7 hit after restart");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule